// File: doc/BRIEF.md
# Versioned Word Store with Wear-Leveling Compaction

This block stores a small set of logical words in an internal record array that can only be cleared one block (sector) at a time. A write never overwrites a word in place. It appends a new record holding the word offset and the data, and the older copy of that offset becomes stale. A read scans the addressed block and returns the data of the highest-numbered valid record for the requested offset. If no record exists, it returns the erased value, which is all ones.

Each block has a fixed number of record slots. A write that finds its block full first compacts the block. The newest value of every offset is gathered into a copy buffer, one offset per cycle. The block is then erased in one cycle, and the buffered words are written back. Only after that does the pending write append its own record. The caller issues one write at a time and watches `busy`. Requests arriving while an operation is in flight are ignored. A whole-array erase is also available. Every completed operation, including a rejected one, sets a sticky interrupt flag that software clears by writing a 1. An enable bit masks this flag onto the interrupt line.

Top module: `wl_word_store`

## Requirements
- R1: After reset, `busy`, `err` and `irq_sts` are 0, and every address reads back all ones.
- R2: An address is `{block, offset}`, with the offset in the low $clog2(WORDS) bits. `rd_data` returns the last data written to that address, or all ones if it has not been written since the last erase.
- R3: A write accepted in idle with a free slot keeps `busy` high for exactly 2 cycles. It consumes one record slot.
- R4: A write to a block whose SLOTS records are all used keeps `busy` high for exactly 2*WORDS+3 cycles. Afterwards, every previously written offset of that block, and of every other block, still reads its latest value, and the new value is visible.
- R5: After compaction, the block holds one record per distinct offset written since its last erase, plus the new record. The next compaction therefore occurs exactly when those slots run out again.
- R6: A write request or erase request presented while `busy` is high is ignored and does not change any stored word.
- R7: A write whose offset is WORDS or more is rejected. `busy` is high for 1 cycle, `err` is 1 when `busy` falls, and no stored word changes. `err` returns to 0 when the next operation is accepted.
- R8: `erase_all` in idle keeps `busy` high for BLOCKS cycles. All addresses then read all ones, and all slots are free. It wins over a simultaneous write request, which is dropped.
- R9: `irq_sts` becomes 1 on the cycle `busy` falls after any write, rejected write or erase. It stays 1 until a cycle with `irq_clr` high and no completion. A completion in the same cycle as `irq_clr` leaves it at 1.
- R10: `irq` is high exactly when `irq_sts` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write request, taken only in idle |
| wr_addr | input | AW | Write address {block, offset} |
| wr_data | input | DW | Write data |
| erase_all | input | 1 | Erase the whole array, taken only in idle |
| rd_addr | input | AW | Read address {block, offset} |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1-to-clear for the interrupt flag |
| busy | output | 1 | Operation in progress, new requests ignored |
| err | output | 1 | Last operation was a rejected write |
| rd_data | output | DW | Newest data for rd_addr, all ones if none |
| irq_sts | output | 1 | Sticky completion flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills blocks until the next write must compact them. It then checks the exact busy length and reads back every address. A design that dropped the trigger word, restored a stale version or picked the wrong record would show a wrong read value. A design that copied records rather than latest words, or miscounted slots after copy-back, would compact one write early or late. The bench pulses requests while busy, so a design that accepted them would change a stored word. It also sends writes to offsets beyond WORDS, which a design that stored them would alias onto a valid offset. Finally, it holds the clear bit across a completion, and a design where clear beats set would lose the interrupt.

// File: rtl/wl_word_store.sv
module wl_word_store #(
  parameter int BLOCKS = 2,
  parameter int WORDS  = 6,
  parameter int SLOTS  = 8,
  parameter int DW     = 16,
  localparam int BW  = $clog2(BLOCKS),
  localparam int OW  = $clog2(WORDS),
  localparam int AW  = BW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          erase_all,
  input  logic [AW-1:0] rd_addr,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          busy,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          irq_sts,
  output logic          irq
);

  localparam int SW  = $clog2(SLOTS + 1);
  localparam int SLW = $clog2(SLOTS);
  localparam int IW  = (OW > BW) ? OW : BW;

  typedef enum logic [2:0] {
    S_IDLE, S_APPEND, S_COMMIT, S_COPY, S_ERASE, S_RESTORE, S_REJECT, S_WIPE
  } state_t;

  state_t state;

  logic          r_vld [BLOCKS][SLOTS];
  logic [OW-1:0] r_off [BLOCKS][SLOTS];
  logic [DW-1:0] r_dat [BLOCKS][SLOTS];
  logic [SW-1:0] fill  [BLOCKS];

  logic          cb_vld [WORDS];
  logic [DW-1:0] cb_dat [WORDS];

  logic [BW-1:0] op_blk;
  logic [OW-1:0] op_off;
  logic [DW-1:0] op_dat;
  logic [IW-1:0] idx;
  logic          err_q, irq_q;

  function automatic logic [DW:0] newest(input logic [BW-1:0] b, input logic [OW-1:0] o);
    logic [DW:0] r;
    r = {1'b0, {DW{1'b1}}};
    for (int s = 0; s < SLOTS; s++)
      if (r_vld[b][s] && r_off[b][s] == o) r = {1'b1, r_dat[b][s]};
    return r;
  endfunction

  logic [BW-1:0] rd_blk, wr_blk;
  logic [OW-1:0] rd_off, wr_off;
  logic [DW:0]   rd_hit, cp_hit;
  logic [SLW-1:0] wslot;
  logic          fin, wr_bad;

  assign rd_blk  = rd_addr[AW-1:OW];
  assign rd_off  = rd_addr[OW-1:0];
  assign wr_blk  = wr_addr[AW-1:OW];
  assign wr_off  = wr_addr[OW-1:0];
  assign wr_bad  = int'(wr_off) >= WORDS;
  assign rd_hit  = newest(rd_blk, rd_off);
  assign rd_data = (int'(rd_off) < WORDS) ? rd_hit[DW-1:0] : {DW{1'b1}};
  assign cp_hit  = newest(op_blk, idx[OW-1:0]);
  assign wslot   = fill[op_blk][SLW-1:0];

  assign busy    = state != S_IDLE;
  assign err     = err_q;
  assign irq_sts = irq_q;
  assign irq     = irq_q & irq_en;
  assign fin     = state == S_COMMIT || state == S_REJECT ||
                   (state == S_WIPE && idx == IW'(BLOCKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_blk <= '0;
      op_off <= '0;
      op_dat <= '0;
      idx    <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      for (int b = 0; b < BLOCKS; b++) begin
        fill[b] <= '0;
        for (int s = 0; s < SLOTS; s++) begin
          r_vld[b][s] <= 1'b0;
          r_off[b][s] <= '1;
          r_dat[b][s] <= '1;
        end
      end
      for (int w = 0; w < WORDS; w++) begin
        cb_vld[w] <= 1'b0;
        cb_dat[w] <= '1;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (erase_all) begin
            state <= S_WIPE;
            idx   <= '0;
            err_q <= 1'b0;
          end else if (wr_req) begin
            op_blk <= wr_blk;
            op_off <= wr_off;
            op_dat <= wr_data;
            err_q  <= 1'b0;
            idx    <= '0;
            if (wr_bad)                       state <= S_REJECT;
            else if (fill[wr_blk] == SW'(SLOTS)) state <= S_COPY;
            else                              state <= S_APPEND;
          end
        end
        S_APPEND: begin
          r_off[op_blk][wslot] <= op_off;
          r_dat[op_blk][wslot] <= op_dat;
          state <= S_COMMIT;
        end
        S_COMMIT: begin
          r_vld[op_blk][wslot] <= 1'b1;
          fill[op_blk] <= fill[op_blk] + SW'(1);
          state <= S_IDLE;
        end
        S_COPY: begin
          cb_vld[idx[OW-1:0]] <= cp_hit[DW];
          cb_dat[idx[OW-1:0]] <= cp_hit[DW-1:0];
          if (idx == IW'(WORDS - 1)) state <= S_ERASE;
          else idx <= idx + IW'(1);
        end
        S_ERASE: begin
          for (int s = 0; s < SLOTS; s++) begin
            r_vld[op_blk][s] <= 1'b0;
            r_off[op_blk][s] <= '1;
            r_dat[op_blk][s] <= '1;
          end
          fill[op_blk] <= '0;
          idx   <= '0;
          state <= S_RESTORE;
        end
        S_RESTORE: begin
          if (cb_vld[idx[OW-1:0]]) begin
            r_vld[op_blk][wslot] <= 1'b1;
            r_off[op_blk][wslot] <= idx[OW-1:0];
            r_dat[op_blk][wslot] <= cb_dat[idx[OW-1:0]];
            fill[op_blk] <= fill[op_blk] + SW'(1);
          end
          if (idx == IW'(WORDS - 1)) state <= S_APPEND;
          else idx <= idx + IW'(1);
        end
        S_REJECT: begin
          err_q <= 1'b1;
          state <= S_IDLE;
        end
        S_WIPE: begin
          for (int s = 0; s < SLOTS; s++) begin
            r_vld[idx[BW-1:0]][s] <= 1'b0;
            r_off[idx[BW-1:0]][s] <= '1;
            r_dat[idx[BW-1:0]][s] <= '1;
          end
          fill[idx[BW-1:0]] <= '0;
          if (idx == IW'(BLOCKS - 1)) state <= S_IDLE;
          else idx <= idx + IW'(1);
        end
        default: state <= S_IDLE;
      endcase
      if (fin)          irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !busy) |=> busy);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill[op_blk] <= SW'(SLOTS));

  // R3
  commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COMMIT) |-> !r_vld[op_blk][wslot]);

  // R5
  erase_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE) |=> (fill[op_blk] == '0));

  // R4
  restore_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RESTORE || state == S_APPEND) |-> (fill[op_blk] < SW'(SLOTS)));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> irq_sts);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fin) |=> !irq_sts);

  // R7
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REJECT) |=> (err && !busy));

endmodule

// File: tb/wl_word_store_bench.sv
`timescale 1ns/1ps
module wl_word_store_bench;
  localparam int BLOCKS = 2;
  localparam int WORDS  = 6;
  localparam int SLOTS  = 8;
  localparam int DW     = 16;
  localparam int OW     = $clog2(WORDS);
  localparam int AW     = $clog2(BLOCKS) + OW;
  localparam int NADDR  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, erase_all = 0, irq_en = 0, irq_clr = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy, err, irq_sts, irq;
  logic [DW-1:0] rd_data;

  wl_word_store #(.BLOCKS(BLOCKS), .WORDS(WORDS), .SLOTS(SLOTS), .DW(DW)) u_wl_word_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_all(erase_all), .rd_addr(rd_addr), .irq_en(irq_en), .irq_clr(irq_clr),
    .busy(busy), .err(err), .rd_data(rd_data), .irq_sts(irq_sts), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  int          m_vld  [BLOCKS][WORDS];
  logic [DW-1:0] m_dat [BLOCKS][WORDS];
  int          m_used [BLOCKS];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(int a);
    int b = a >> OW;
    int o = a & ((1 << OW) - 1);
    if (o >= WORDS || !m_vld[b][o]) return '1;
    return m_dat[b][o];
  endfunction

  function automatic void model_clear();
    for (int b = 0; b < BLOCKS; b++) begin
      m_used[b] = 0;
      for (int w = 0; w < WORDS; w++) begin m_vld[b][w] = 0; m_dat[b][w] = '1; end
    end
  endfunction

  task automatic read_all(string req);
    for (int a = 0; a < NADDR; a++) begin
      rd_addr = AW'(a);
      #1;
      check(req, 32'(rd_data), 32'(exp_read(a)));
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  // model-driven write: returns nothing, checks busy length, err and irq
  task automatic do_write(int a, logic [DW-1:0] d, bit hold_clr, bit poke);
    int b = a >> OW;
    int o = a & ((1 << OW) - 1);
    int exp_n, n, nv;
    if (o >= WORDS) exp_n = 1;
    else if (m_used[b] == SLOTS) exp_n = 2 * WORDS + 3;
    else exp_n = 2;
    @(negedge clk);
    wr_addr = AW'(a); wr_data = d; wr_req = 1; irq_clr = hold_clr;
    @(negedge clk);
    wr_req = 0;
    if (poke && busy) begin
      wr_addr = AW'(a ^ 1); wr_data = ~d; wr_req = 1; erase_all = 1;
      @(negedge clk);
      wr_req = 0; erase_all = 0;
      n = 1;
    end else n = 0;
    begin int k; wait_idle(k); n += k; end
    irq_clr = 0;
    if (o >= WORDS) begin
      check("R7 busy", 32'(n), 32'(exp_n));
      check("R7 err", 32'(err), 32'd1);
    end else begin
      if (exp_n == 2) check("R3 busy", 32'(n), 32'(exp_n));
      else            check("R4 busy", 32'(n), 32'(exp_n));
      check("R7 err clears", 32'(err), 32'd0);
      if (m_used[b] == SLOTS) begin
        nv = 0;
        for (int w = 0; w < WORDS; w++) nv += m_vld[b][w];
        m_used[b] = nv + 1;
      end else m_used[b]++;
      m_vld[b][o] = 1; m_dat[b][o] = d;
    end
    check("R9 irq_sts", 32'(irq_sts), 32'd1);
    check("R10 irq", 32'(irq), 32'(irq_en));
  endtask

  task automatic do_erase(bit with_write);
    int n;
    @(negedge clk);
    erase_all = 1; wr_req = with_write; wr_addr = '0; wr_data = 16'h1234;
    @(negedge clk);
    erase_all = 0; wr_req = 0;
    wait_idle(n);
    check("R8 busy", 32'(n), 32'(BLOCKS));
    check("R8 err", 32'(err), 32'd0);
    check("R9 irq after erase", 32'(irq_sts), 32'd1);
    model_clear();
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R9 cleared", 32'(irq_sts), 32'd0);
    check("R10 irq low", 32'(irq), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done_flag) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    #9 rst_n = 1;
    @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 err", 32'(err), 0);
    check("R1 irq_sts", 32'(irq_sts), 0);
    read_all("R1/R2 erased read");

    irq_en = 1;
    do_write(0, 16'hA5A5, 0, 0);
    read_all("R2 read after write");
    clear_irq();

    // fill block 0 to the limit with repeats of two offsets, then compact
    for (int i = 0; i < SLOTS - 1; i++) do_write(i % 2 == 0 ? 1 : 2, DW'(16'h100 + i), 0, 0);
    do_write(3, 16'hBEEF, 0, 0);
    read_all("R4 after compaction");
    // fill exactly reaches SLOTS again; verify R5 timing
    while (m_used[0] < SLOTS) do_write(2, DW'($urandom), 0, 0);
    do_write(5, 16'h5555, 0, 0);
    read_all("R5 second compaction");

    // R6: requests while busy are ignored
    do_write(8, 16'h0F0F, 0, 1);
    read_all("R6 ignored request");

    // R7: offset beyond WORDS
    irq_en = 0;
    do_write(7, 16'hDEAD, 0, 0);
    read_all("R7 no change");
    do_write(14, 16'hDEAD, 0, 0);
    do_write(9, 16'h9999, 0, 0);

    // R9: set wins over simultaneous clear
    irq_en = 1;
    do_write(10, 16'h7777, 1, 0);

    // R8: erase beats write
    do_erase(1);
    read_all("R8 erased");
    do_write(0, 16'h4242, 0, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      irq_en = $urandom % 2;
      if (r < 2) do_erase($urandom % 2);
      else if (r < 8) clear_irq();
      else if (r < 60) do_write($urandom % 2 == 0 ? 2 : 11, DW'($urandom), $urandom % 4 == 0, $urandom % 8 == 0);
      else do_write($urandom % NADDR, DW'($urandom), $urandom % 4 == 0, $urandom % 8 == 0);
      if (i % 10 == 0) read_all("R2 random readback");
    end
    read_all("R4 final readback");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule